// File: doc/BRIEF.md
# Routed General-Purpose I/O Port

This block controls an 8-pin general-purpose I/O port from a small register interface. Software sets a latched output value, a direction per pin, a pull device per pin (enable and up/down selection) and a reduced-drive flag per pin. Software can also read back the pin levels. Reads of pin levels pass through a two-flop synchronizer, so a change on a pin shows up in the readable registers two clocks later.

Two on-chip peripherals can take over pins: a timer on all eight pins and a PWM unit on the lower five. A routing register picks one of the two for each of the lower five pins. When the selected peripheral asserts its output enable on a pin, that pin becomes an output driven by the peripheral. The stored direction bit is left untouched, and it controls the pin again once the peripheral lets go.

The timer's capture input always gets the synchronized pin level. All pad-side outputs are registered and follow their cause by one clock. The bus is single-cycle: a write takes effect at the clock edge, and read data is combinational from the address.

Top module: `gpio_route_port`

## Requirements
- R1: A synchronous active-high reset clears every writable register, the synchronizer and all pad outputs to zero.
- R2: Reading address 0 returns, per pin, the latched data bit when the direction bit is 1 and the synchronized pin level when it is 0.
- R3: Reading address 1 returns the synchronized pin levels whatever the direction, and writes to address 1 change nothing.
- R4: Address 2 holds the direction (1 = output). With no peripheral active, a pin with direction 1 has pad_oe = 1 and pad_out = its data bit (address 0).
- R5: When the peripheral selected for a pin asserts its output enable, pad_oe is 1 and pad_out follows that peripheral's output. The direction register reads back unchanged, and it controls the pin again once the enable drops.
- R6: Routing bit i (address 7, bits 4:0) set to 1 makes the PWM unit the peripheral for pin i, and 0 makes it the timer. Pins 7:5 always use the timer.
- R7: Routing bits 7:5 read as 0 and ignore writes.
- R8: Address 5 bit 1 selects a pull-down on pad_pull_dn and 0 selects a pull-up. pad_pull_en is 1 only when the address 4 enable bit is set and the pin is not acting as an output.
- R9: A pin level change applied before clock edge k is not visible at address 1 after edge k, and is visible after edge k+1.
- R10: tmr_cap always equals the synchronized pin levels, whatever the direction, routing or peripheral state.
- R11: Address 6 reads as zero and ignores writes.
- R12: Address 3 holds the reduced-drive bits, which read back and appear on pad_rdrv.
- R13: Pad outputs are registered and take their new value one clock after the register write or peripheral input that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_in | input | 8 | Pin levels seen at the pads (asynchronous) |
| tmr_oe | input | 8 | Timer output enable per pin |
| tmr_out | input | 8 | Timer output value per pin |
| pwm_oe | input | 5 | PWM output enable for pins 4:0 |
| pwm_out | input | 5 | PWM output value for pins 4:0 |
| tmr_cap | output | 8 | Synchronized pin levels for timer capture |
| pad_oe | output | 8 | Pad output enable |
| pad_out | output | 8 | Pad output value |
| pad_pull_en | output | 8 | Pull device enable |
| pad_pull_dn | output | 8 | Pull direction, 1 = pull-down |
| pad_rdrv | output | 8 | Reduced-drive select |

## Verification
The hardest case to reach from the ports is a peripheral override on a pin whose direction bit disagrees with it, while the routing bit for that pin switches between the two peripherals. The stimulus sets direction and data first. It then raises the timer and PWM enables with opposite output values on the same pin and flips the routing bit. It reads the direction register back during the override and after the release, to show that the stored bit was neither lost nor changed. A long phase of pseudo-random writes, peripheral enables and pin changes then runs against a behavioural model, so that overrides, pulls and synchronizer delay meet in many combinations.

// File: rtl/gpio_route_pkg.sv
package gpio_route_pkg;
  typedef enum logic [2:0] {
    ADDR_DATA    = 3'd0,
    ADDR_PINS    = 3'd1,
    ADDR_DIR     = 3'd2,
    ADDR_DRIVE   = 3'd3,
    ADDR_PULLEN  = 3'd4,
    ADDR_PULLSEL = 3'd5,
    ADDR_RSVD    = 3'd6,
    ADDR_ROUTE   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_async,
  output logic [WIDTH-1:0] pin_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= pin_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_route_regs.sv
module gpio_route_regs
  import gpio_route_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int ROUTE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         bus_addr,
  input  logic               bus_we,
  input  logic [WIDTH-1:0]   bus_wdata,
  output logic [WIDTH-1:0]   bus_rdata,
  input  logic [WIDTH-1:0]   pin_sync,
  output logic [WIDTH-1:0]   data_q,
  output logic [WIDTH-1:0]   dir_q,
  output logic [WIDTH-1:0]   drv_q,
  output logic [WIDTH-1:0]   pen_q,
  output logic [WIDTH-1:0]   pps_q,
  output logic [ROUTE_W-1:0] route_q
);
  localparam int PAD_W = WIDTH - ROUTE_W;

  reg_addr_e sel;
  assign sel = reg_addr_e'(bus_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dir_q   <= '0;
      drv_q   <= '0;
      pen_q   <= '0;
      pps_q   <= '0;
      route_q <= '0;
    end else if (bus_we) begin
      case (sel)
        ADDR_DATA:    data_q  <= bus_wdata;
        ADDR_DIR:     dir_q   <= bus_wdata;
        ADDR_DRIVE:   drv_q   <= bus_wdata;
        ADDR_PULLEN:  pen_q   <= bus_wdata;
        ADDR_PULLSEL: pps_q   <= bus_wdata;
        ADDR_ROUTE:   route_q <= bus_wdata[ROUTE_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      ADDR_DATA:    bus_rdata = (dir_q & data_q) | (~dir_q & pin_sync);
      ADDR_PINS:    bus_rdata = pin_sync;
      ADDR_DIR:     bus_rdata = dir_q;
      ADDR_DRIVE:   bus_rdata = drv_q;
      ADDR_PULLEN:  bus_rdata = pen_q;
      ADDR_PULLSEL: bus_rdata = pps_q;
      ADDR_ROUTE:   bus_rdata = {{PAD_W{1'b0}}, route_q};
      default:      bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int WIDTH   = 8,
  parameter int ROUTE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WIDTH-1:0]   data_q,
  input  logic [WIDTH-1:0]   dir_q,
  input  logic [WIDTH-1:0]   drv_q,
  input  logic [WIDTH-1:0]   pen_q,
  input  logic [WIDTH-1:0]   pps_q,
  input  logic [ROUTE_W-1:0] route_q,
  input  logic [WIDTH-1:0]   tmr_oe,
  input  logic [WIDTH-1:0]   tmr_out,
  input  logic [ROUTE_W-1:0] pwm_oe,
  input  logic [ROUTE_W-1:0] pwm_out,
  output logic [WIDTH-1:0]   pad_oe,
  output logic [WIDTH-1:0]   pad_out,
  output logic [WIDTH-1:0]   pad_pull_en,
  output logic [WIDTH-1:0]   pad_pull_dn,
  output logic [WIDTH-1:0]   pad_rdrv
);
  logic [WIDTH-1:0] per_oe, per_val, oe_d, out_d, pe_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i < ROUTE_W) begin : g_routed
      assign per_oe[i]  = route_q[i] ? pwm_oe[i]  : tmr_oe[i];
      assign per_val[i] = route_q[i] ? pwm_out[i] : tmr_out[i];
    end else begin : g_timer_only
      assign per_oe[i]  = tmr_oe[i];
      assign per_val[i] = tmr_out[i];
    end
    assign oe_d[i]  = per_oe[i] | dir_q[i];
    assign out_d[i] = per_oe[i] ? per_val[i] : data_q[i];
    assign pe_d[i]  = pen_q[i] & ~oe_d[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe      <= '0;
      pad_out     <= '0;
      pad_pull_en <= '0;
      pad_pull_dn <= '0;
      pad_rdrv    <= '0;
    end else begin
      pad_oe      <= oe_d;
      pad_out     <= out_d;
      pad_pull_en <= pe_d;
      pad_pull_dn <= pps_q;
      pad_rdrv    <= drv_q;
    end
  end
endmodule

// File: rtl/gpio_route_port.sv
module gpio_route_port #(
  parameter int WIDTH       = 8,
  parameter int ROUTE_W     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         bus_addr,
  input  logic               bus_we,
  input  logic [WIDTH-1:0]   bus_wdata,
  output logic [WIDTH-1:0]   bus_rdata,
  input  logic [WIDTH-1:0]   pin_in,
  input  logic [WIDTH-1:0]   tmr_oe,
  input  logic [WIDTH-1:0]   tmr_out,
  input  logic [ROUTE_W-1:0] pwm_oe,
  input  logic [ROUTE_W-1:0] pwm_out,
  output logic [WIDTH-1:0]   tmr_cap,
  output logic [WIDTH-1:0]   pad_oe,
  output logic [WIDTH-1:0]   pad_out,
  output logic [WIDTH-1:0]   pad_pull_en,
  output logic [WIDTH-1:0]   pad_pull_dn,
  output logic [WIDTH-1:0]   pad_rdrv
);
  logic [WIDTH-1:0]   pin_sync, data_q, dir_q, drv_q, pen_q, pps_q;
  logic [ROUTE_W-1:0] route_q;

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_async(pin_in), .pin_sync(pin_sync)
  );

  gpio_route_regs #(.WIDTH(WIDTH), .ROUTE_W(ROUTE_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_sync(pin_sync),
    .data_q(data_q), .dir_q(dir_q), .drv_q(drv_q), .pen_q(pen_q),
    .pps_q(pps_q), .route_q(route_q)
  );

  gpio_pad_ctrl #(.WIDTH(WIDTH), .ROUTE_W(ROUTE_W)) u_pad (
    .clk(clk), .rst(rst), .data_q(data_q), .dir_q(dir_q), .drv_q(drv_q),
    .pen_q(pen_q), .pps_q(pps_q), .route_q(route_q),
    .tmr_oe(tmr_oe), .tmr_out(tmr_out), .pwm_oe(pwm_oe), .pwm_out(pwm_out),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
    .pad_pull_dn(pad_pull_dn), .pad_rdrv(pad_rdrv)
  );

  assign tmr_cap = pin_sync;
endmodule

// File: rtl/gpio_route_port_chk.sv
module gpio_route_port_chk #(
  parameter int WIDTH   = 8,
  parameter int ROUTE_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         bus_addr,
  input logic               bus_we,
  input logic [WIDTH-1:0]   bus_wdata,
  input logic [WIDTH-1:0]   bus_rdata,
  input logic [WIDTH-1:0]   pin_in,
  input logic [WIDTH-1:0]   tmr_oe,
  input logic [WIDTH-1:0]   tmr_out,
  input logic [ROUTE_W-1:0] pwm_oe,
  input logic [ROUTE_W-1:0] pwm_out,
  input logic [WIDTH-1:0]   tmr_cap,
  input logic [WIDTH-1:0]   pad_oe,
  input logic [WIDTH-1:0]   pad_out,
  input logic [WIDTH-1:0]   pad_pull_en,
  input logic [WIDTH-1:0]   pad_pull_dn,
  input logic [WIDTH-1:0]   pad_rdrv
);
  logic [1:0] live_cnt;
  always_ff @(posedge clk) begin
    if (rst) live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  a_r7_route_upper_zero: assert property (@(posedge clk) disable iff (rst)
    bus_addr == 3'd7 |-> bus_rdata[WIDTH-1:ROUTE_W] == '0);

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_addr == 3'd6 |-> bus_rdata == '0);

  a_r9_status_two_cycles: assert property (@(posedge clk) disable iff (rst)
    (live_cnt >= 2'd2 && bus_addr == 3'd1) |-> bus_rdata == $past(pin_in, 2));

  a_r10_cap_matches_status: assert property (@(posedge clk) disable iff (rst)
    bus_addr == 3'd1 |-> bus_rdata == tmr_cap);

  a_r8_no_pull_on_output: assert property (@(posedge clk) disable iff (rst)
    (pad_pull_en & pad_oe) == '0);

  a_r5_timer_override_top: assert property (@(posedge clk) disable iff (rst)
    (live_cnt >= 2'd1 && $past(tmr_oe[WIDTH-1]))
      |-> (pad_oe[WIDTH-1] && pad_out[WIDTH-1] == $past(tmr_out[WIDTH-1])));
endmodule

bind gpio_route_port gpio_route_port_chk #(.WIDTH(WIDTH), .ROUTE_W(ROUTE_W)) u_chk (.*);

// File: tb/gpio_route_port_tb.sv
module gpio_route_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0, tmr_oe = '0, tmr_out = '0;
  logic [4:0] pwm_oe = '0, pwm_out = '0;
  logic [7:0] tmr_cap, pad_oe, pad_out, pad_pull_en, pad_pull_dn, pad_rdrv;

  int n_checks = 0;
  int n_errors = 0;
  bit running = 0;

  always #5 clk = ~clk;

  gpio_route_port u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .tmr_oe(tmr_oe), .tmr_out(tmr_out), .pwm_oe(pwm_oe), .pwm_out(pwm_out),
    .tmr_cap(tmr_cap), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pull_en(pad_pull_en), .pad_pull_dn(pad_pull_dn), .pad_rdrv(pad_rdrv)
  );

  // Behavioural reference model
  bit [7:0] m_data, m_dir, m_drv, m_pen, m_pps, m_route;
  bit [7:0] m_pipe [$];
  bit [7:0] m_oe, m_out, m_pe, m_pd, m_rd;

  function automatic bit [7:0] m_sync();
    return m_pipe[1];
  endfunction

  initial begin
    m_pipe.push_back(8'h00);
    m_pipe.push_back(8'h00);
  end

  always @(posedge clk) begin
    bit [7:0] poe, pval;
    if (rst) begin
      m_data = 0; m_dir = 0; m_drv = 0; m_pen = 0; m_pps = 0; m_route = 0;
      m_pipe.delete(); m_pipe.push_back(8'h00); m_pipe.push_back(8'h00);
      m_oe = 0; m_out = 0; m_pe = 0; m_pd = 0; m_rd = 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (i < 5 && m_route[i]) begin
          poe[i] = pwm_oe[i]; pval[i] = pwm_out[i];
        end else begin
          poe[i] = tmr_oe[i]; pval[i] = tmr_out[i];
        end
        m_oe[i]  = poe[i] | m_dir[i];
        m_out[i] = poe[i] ? pval[i] : m_data[i];
        m_pe[i]  = m_pen[i] && !m_oe[i];
      end
      m_pd = m_pps;
      m_rd = m_drv;
      void'(m_pipe.pop_back());
      m_pipe.push_front(pin_in);
      if (bus_we) begin
        case (bus_addr)
          3'd0: m_data = bus_wdata;
          3'd2: m_dir = bus_wdata;
          3'd3: m_drv = bus_wdata;
          3'd4: m_pen = bus_wdata;
          3'd5: m_pps = bus_wdata;
          3'd7: m_route = {3'b000, bus_wdata[4:0]};
          default: ;
        endcase
      end
    end
  end

  function automatic bit [7:0] m_read(input bit [2:0] a);
    bit [7:0] s = m_sync();
    case (a)
      3'd0: return (m_dir & m_data) | (~m_dir & s);
      3'd1: return s;
      3'd2: return m_dir;
      3'd3: return m_drv;
      3'd4: return m_pen;
      3'd5: return m_pps;
      3'd7: return m_route;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the edge
  always begin
    @(posedge clk);
    #4;
    if (running) begin
      check("R2 rdata vs model", bus_rdata, m_read(bus_addr));
      check("R10 tmr_cap", tmr_cap, m_sync());
      check("R5 pad_oe", pad_oe, m_oe);
      check("R4 pad_out", pad_out, m_out);
      check("R8 pad_pull_en", pad_pull_en, m_pe);
      check("R8 pad_pull_dn", pad_pull_dn, m_pd);
      check("R12 pad_rdrv", pad_rdrv, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    #4;
  endtask

  initial begin
    #1500000;
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    running = 1;
    #1;
    // R1: reset state
    check("R1 pad_oe after reset", pad_oe, 8'h00);
    check("R1 pad_pull_en after reset", pad_pull_en, 8'h00);
    rd_check("R1 dir after reset", 3'd2, 8'h00);
    rd_check("R1 route after reset", 3'd7, 8'h00);

    // R7 upper routing bits
    wr(3'd7, 8'hFF);
    rd_check("R7 route upper bits", 3'd7, 8'h1F);
    wr(3'd7, 8'h00);

    // R11 reserved
    wr(3'd6, 8'hAA);
    rd_check("R11 reserved read", 3'd6, 8'h00);

    // R9 synchronizer latency
    @(negedge clk);
    bus_addr = 3'd1;
    pin_in = 8'h5A;
    tick();
    check("R9 not yet visible", bus_rdata, 8'h00);
    tick();
    check("R9 visible after two edges", bus_rdata, 8'h5A);

    // R2 / R4 data read mux and outputs
    wr(3'd0, 8'h0F);
    wr(3'd2, 8'h33);
    rd_check("R2 mixed direction read", 3'd0, 8'h4B);
    tick();
    check("R4 pad_oe from dir", pad_oe, 8'h33);
    check("R4 pad_out from data", pad_out & pad_oe, 8'h03);
    check("R13 pad_out registered", pad_out, 8'h0F);

    // R3 writes to status ignored
    wr(3'd1, 8'hFF);
    rd_check("R3 status unchanged by write", 3'd1, 8'h5A);
    rd_check("R3 dir unchanged by status write", 3'd2, 8'h33);

    // R5 timer override on pin 7, and release
    @(negedge clk);
    tmr_oe = 8'h80; tmr_out = 8'h80;
    tick();
    check("R5 override oe", pad_oe, 8'hB3);
    check("R5 override value", pad_out[7], 1'b1);
    rd_check("R5 dir kept during override", 3'd2, 8'h33);
    @(negedge clk);
    tmr_oe = 8'h00;
    tick();
    check("R5 dir resumes after release", pad_oe, 8'h33);

    // R6 routing pin 2 between timer and PWM (dir bit 2 is 0)
    @(negedge clk);
    tmr_oe = 8'h04; tmr_out = 8'h04; pwm_oe = 5'h04; pwm_out = 5'h00;
    tick();
    check("R6 timer drives pin 2", pad_out[2], 1'b1);
    wr(3'd7, 8'h04);
    tick();
    check("R6 pwm drives pin 2", pad_out[2], 1'b0);
    @(negedge clk);
    pwm_oe = 5'h00;
    tick();
    check("R6 pwm released, pin 2 input", pad_oe[2], 1'b0);
    @(negedge clk);
    tmr_oe = 8'h00; tmr_out = 8'h00;
    wr(3'd7, 8'h00);

    // R8 pulls only on inputs
    wr(3'd4, 8'hFF);
    wr(3'd5, 8'hF0);
    tick();
    check("R8 pull enable on inputs only", pad_pull_en, 8'hCC);
    check("R8 pull polarity", pad_pull_dn, 8'hF0);

    // R10 capture sees pins with all outputs
    wr(3'd2, 8'hFF);
    @(negedge clk);
    pin_in = 8'hC3;
    tick(); tick();
    check("R10 capture with all outputs", tmr_cap, 8'hC3);

    // R12 reduced drive
    wr(3'd3, 8'h3C);
    rd_check("R12 drive readback", 3'd3, 8'h3C);
    tick();
    check("R12 pad_rdrv", pad_rdrv, 8'h3C);

    // Mixed pseudo-random traffic against the model
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      pin_in   = 8'($urandom);
      tmr_oe   = 8'($urandom) & 8'($urandom);
      tmr_out  = 8'($urandom);
      pwm_oe   = 5'($urandom);
      pwm_out  = 5'($urandom);
      bus_addr = 3'($urandom);
      bus_we   = ($urandom % 3) == 0;
      bus_wdata = 8'($urandom);
    end
    @(negedge clk);
    bus_we = 1'b0;

    // R1 reset again mid-run
    rst = 1'b1;
    tick();
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 pad_oe after second reset", pad_oe, 8'h00);
    rd_check("R1 pull enable after second reset", 3'd4, 8'h00);
    tick();

    running = 0;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule